// File: doc/BRIEF.md
# Bus-Safe Edge Event Capture Register

This block sits behind a bank of already-debounced input ports, each carrying `W` channels. Every port passes through a holding latch, a two-stage synchroniser and an edge detector. The synchronised level is loaded into a data register. Rising and falling transitions set bits in two separate sticky event registers, and each event register has its own mask. While a host bus transaction to a port is in progress, and for a fixed number of cycles after it ends, that port's inputs are frozen in the latch. Input changes during that window are therefore delayed, not lost.

Each port has its own control register. One control bit enables the edge interrupt and another enables the data-available interrupt. A third bit chooses how the data register is loaded: from the internal clock on every cycle, or on the synchronised rising edge of an external capture strobe. A shared status register holds a bank-select bit, which decides which half of the ports a host register access reaches. Registered status outputs report one edge flag and one data-available flag per port, and a single interrupt request combines them.

The host interface uses one-cycle write and read strobes, a 3-bit register code and a pair index. Read data is registered and appears one cycle after the read strobe.

Top module: `edge_event_capture`

## Requirements
- R1: While `bus_xact[p]` is high, and for `HOLD_EXT` cycles after it falls, a change on port p's inputs does not reach that port's data or event registers. Once the window has closed, the change does arrive.
- R2: In internal mode, an input change driven before clock edge 1 is loaded into the data register at edge 4. A read strobe sampled at edge 4 still returns the old value, and a read strobe sampled at edge 5 returns the new one.
- R3: When control bit 2 is 1 (external mode), the data register loads only on a rising edge of `ext_cap[p]`, after a two-flop synchroniser. Input changes with no strobe leave it unchanged.
- R4: An unmasked 0-to-1 channel transition sets the matching bit of the rising-event register (code 4). An unmasked 1-to-0 transition sets the matching bit of the falling-event register (code 5).
- R5: A 1 in the rising mask (code 2) or the falling mask (code 3) stops that channel's transition of that type from setting its event bit.
- R6: Event bits stay set until the host writes 1 to them. If an event sets a bit on the same cycle that the host clears it, the bit stays set.
- R7: A port's data-available flag sets when its data register loads a changed value in internal mode, or on every external capture in external mode. A read of the data register (code 1) clears it. A set in the same cycle wins over the clear.
- R8: The `stat_edge[p]` output is the OR of port p's rising and falling event bits, and `stat_dav[p]` is its data-available flag. Both are registered, one cycle after the flags. Reading status (code 7) returns the bank-select bit in bit 0, the edge flags in bits 1 to NPORT, and the data-available flags in the NPORT bits above those.
- R9: `irq` is the OR over all ports of (edge flag AND control bit 0) together with (data-available flag AND control bit 1). It is registered, and it is 0 whenever no enable bit is set.
- R10: Writing status bit 0 sets the bank. The port reached by an access is bank*NPAIR + `host_pair`. After reset the bank is 0.
- R11: After reset, every register, flag, `host_rdata`, `stat_edge`, `stat_dav` and `irq` read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| chan_in | input | NPORT*W | Debounced channel levels, port p at bits [p*W +: W] |
| bus_xact | input | NPORT | Host transaction in progress on each port |
| ext_cap | input | NPORT | Asynchronous external capture strobe per port |
| host_wr | input | 1 | One-cycle register write strobe |
| host_rd | input | 1 | One-cycle register read strobe |
| host_reg | input | 3 | Register code (0 ctrl, 1 data, 2/3 masks, 4/5 events, 7 status) |
| host_pair | input | PW | Port index within the selected bank |
| host_wdata | input | W | Write data |
| host_rdata | output | W | Registered read data |
| stat_edge | output | NPORT | Per-port edge flag |
| stat_dav | output | NPORT | Per-port data-available flag |
| irq | output | 1 | Combined interrupt request |

## Verification
A latch that fails to freeze lets a mid-transaction change reach the data register about four cycles after the change. That shows up as a new value read back while `bus_xact` is still high. An event register that drops its set-versus-clear race loses a bit that should survive, and the next event read shows it. A wrong bank or a wrong status bit order shows up on the very next read, as data from the wrong port or flags in the wrong positions. A wrong interrupt combination shows on `irq` within two cycles of an enable being written.

// File: rtl/evcap_pkg.sv
package evcap_pkg;
  typedef enum logic [2:0] {
    RG_CTRL  = 3'd0,
    RG_DATA  = 3'd1,
    RG_RMASK = 3'd2,
    RG_FMASK = 3'd3,
    RG_REVT  = 3'd4,
    RG_FEVT  = 3'd5,
    RG_RSVD  = 3'd6,
    RG_STAT  = 3'd7
  } reg_e;

  localparam int CB_EDGE_EN = 0;
  localparam int CB_DAV_EN  = 1;
  localparam int CB_EXT_SEL = 2;
  localparam int CTRL_W     = 3;
endpackage

// File: rtl/evcap_hold.sv
module evcap_hold #(
  parameter int W        = 16,
  parameter int HOLD_EXT = 25
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  input  logic         xact,
  output logic [W-1:0] smp
);
  localparam int CW = $clog2(HOLD_EXT + 1);

  logic [CW-1:0] ext_cnt;
  logic          hold;
  logic [W-1:0]  lat_q, s1_q, s2_q;

  assign hold = xact | (ext_cnt != '0);
  assign smp  = s2_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ext_cnt <= '0;
      lat_q   <= '0;
      s1_q    <= '0;
      s2_q    <= '0;
    end else begin
      if (xact)
        ext_cnt <= CW'(HOLD_EXT);
      else if (ext_cnt != '0)
        ext_cnt <= ext_cnt - 1'b1;
      if (!hold)
        lat_q <= din;
      s1_q <= lat_q;
      s2_q <= s1_q;
    end
  end

  // R1
  latch_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    xact |=> (lat_q == $past(lat_q)));

  // R1
  latch_ext_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(xact) |=> $stable(lat_q));
endmodule

// File: rtl/evcap_sync2.sv
module evcap_sync2 (
  input  logic clk,
  input  logic rst,
  input  logic a,
  output logic rise
);
  logic s1_q, s2_q, s3_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= a;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign rise = s2_q & ~s3_q;
endmodule

// File: rtl/evcap_port.sv
module evcap_port
  import evcap_pkg::*;
#(
  parameter int W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [W-1:0]      smp,
  input  logic              ext_rise,
  input  logic              wr_en,
  input  logic              rd_en,
  input  reg_e              reg_sel,
  input  logic [W-1:0]      wdata,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic [W-1:0]      data_q,
  output logic [W-1:0]      rmask_q,
  output logic [W-1:0]      fmask_q,
  output logic [W-1:0]      revt_q,
  output logic [W-1:0]      fevt_q,
  output logic              edge_flag,
  output logic              dav_q
);
  logic [W-1:0] prev_q;
  logic [W-1:0] rise_v, fall_v, rclr, fclr;
  logic         load, dav_set, dav_clr, ext_mode;

  assign ext_mode = ctrl_q[CB_EXT_SEL];
  assign rise_v   = smp & ~prev_q & ~rmask_q;
  assign fall_v   = ~smp & prev_q & ~fmask_q;
  assign rclr     = (wr_en && reg_sel == RG_REVT) ? wdata : '0;
  assign fclr     = (wr_en && reg_sel == RG_FEVT) ? wdata : '0;
  assign load     = ext_mode ? ext_rise : 1'b1;
  assign dav_set  = ext_mode ? ext_rise : (smp != data_q);
  assign dav_clr  = rd_en && reg_sel == RG_DATA;
  assign edge_flag = |{revt_q, fevt_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= '0;
      rmask_q <= '0;
      fmask_q <= '0;
      prev_q  <= '0;
      data_q  <= '0;
      revt_q  <= '0;
      fevt_q  <= '0;
      dav_q   <= 1'b0;
    end else begin
      if (wr_en) begin
        case (reg_sel)
          RG_CTRL:  ctrl_q  <= wdata[CTRL_W-1:0];
          RG_RMASK: rmask_q <= wdata;
          RG_FMASK: fmask_q <= wdata;
          default: ;
        endcase
      end
      prev_q <= smp;
      if (load)
        data_q <= smp;
      revt_q <= (revt_q & ~rclr) | rise_v;
      fevt_q <= (fevt_q & ~fclr) | fall_v;
      dav_q  <= dav_set | (dav_q & ~dav_clr);
    end
  end

  // R6
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    ((rise_v & rclr) != '0) |=> ((revt_q & $past(rise_v & rclr)) == $past(rise_v & rclr)));

  // R6
  sticky_evt_chk: assert property (@(posedge clk) disable iff (rst)
    (rclr == '0) |=> ((revt_q & $past(revt_q)) == $past(revt_q)));

  // R5
  mask_block_chk: assert property (@(posedge clk) disable iff (rst)
    (rmask_q != '0) |=> ((revt_q & $past(rmask_q & ~revt_q)) == '0));

  // R3
  ext_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ext_mode && !ext_rise) |=> $stable(data_q));
endmodule

// File: rtl/edge_event_capture.sv
module edge_event_capture
  import evcap_pkg::*;
#(
  parameter int W        = 16,
  parameter int NPAIR    = 2,
  parameter int HOLD_EXT = 25,
  localparam int NPORT   = 2 * NPAIR,
  localparam int PW      = $clog2(NPAIR)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NPORT*W-1:0] chan_in,
  input  logic [NPORT-1:0]   bus_xact,
  input  logic [NPORT-1:0]   ext_cap,
  input  logic               host_wr,
  input  logic               host_rd,
  input  logic [2:0]         host_reg,
  input  logic [PW-1:0]      host_pair,
  input  logic [W-1:0]       host_wdata,
  output logic [W-1:0]       host_rdata,
  output logic [NPORT-1:0]   stat_edge,
  output logic [NPORT-1:0]   stat_dav,
  output logic               irq
);
  // NPAIR must be a power of two (two or more); 2*NPORT+1 must fit in W.
  localparam int SW = PW + 1;

  reg_e                           rsel;
  logic                           bank_q;
  logic [SW-1:0]                  port_idx;
  logic [NPORT-1:0]               p_wr, p_rd, ext_rise, ef, dv, een, den;
  logic [NPORT-1:0][W-1:0]        smp, data_a, rmask_a, fmask_a, revt_a, fevt_a;
  logic [NPORT-1:0][CTRL_W-1:0]   ctrl_a;
  logic [W-1:0]                   stat_word, rd_mux;

  assign rsel     = reg_e'(host_reg);
  assign port_idx = {bank_q, host_pair};

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    assign p_wr[p] = host_wr && (port_idx == SW'(p)) && (rsel != RG_STAT);
    assign p_rd[p] = host_rd && (port_idx == SW'(p)) && (rsel != RG_STAT);
    assign een[p]  = ctrl_a[p][CB_EDGE_EN];
    assign den[p]  = ctrl_a[p][CB_DAV_EN];

    evcap_hold #(.W(W), .HOLD_EXT(HOLD_EXT)) u_hold (
      .clk  (clk),
      .rst  (rst),
      .din  (chan_in[p*W +: W]),
      .xact (bus_xact[p]),
      .smp  (smp[p])
    );

    evcap_sync2 u_xsync (
      .clk  (clk),
      .rst  (rst),
      .a    (ext_cap[p]),
      .rise (ext_rise[p])
    );

    evcap_port #(.W(W)) u_port (
      .clk       (clk),
      .rst       (rst),
      .smp       (smp[p]),
      .ext_rise  (ext_rise[p]),
      .wr_en     (p_wr[p]),
      .rd_en     (p_rd[p]),
      .reg_sel   (rsel),
      .wdata     (host_wdata),
      .ctrl_q    (ctrl_a[p]),
      .data_q    (data_a[p]),
      .rmask_q   (rmask_a[p]),
      .fmask_q   (fmask_a[p]),
      .revt_q    (revt_a[p]),
      .fevt_q    (fevt_a[p]),
      .edge_flag (ef[p]),
      .dav_q     (dv[p])
    );
  end

  always_comb begin
    stat_word = '0;
    stat_word[0] = bank_q;
    stat_word[NPORT:1] = ef;
    stat_word[2*NPORT:NPORT+1] = dv;
  end

  always_comb begin
    case (rsel)
      RG_CTRL:  rd_mux = W'(ctrl_a[port_idx]);
      RG_DATA:  rd_mux = data_a[port_idx];
      RG_RMASK: rd_mux = rmask_a[port_idx];
      RG_FMASK: rd_mux = fmask_a[port_idx];
      RG_REVT:  rd_mux = revt_a[port_idx];
      RG_FEVT:  rd_mux = fevt_a[port_idx];
      RG_STAT:  rd_mux = stat_word;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bank_q     <= 1'b0;
      host_rdata <= '0;
      stat_edge  <= '0;
      stat_dav   <= '0;
      irq        <= 1'b0;
    end else begin
      if (host_wr && rsel == RG_STAT)
        bank_q <= host_wdata[0];
      if (host_rd)
        host_rdata <= rd_mux;
      stat_edge <= ef;
      stat_dav  <= dv;
      irq       <= |((ef & een) | (dv & den));
    end
  end

  // R9
  irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    ((een | den) == '0) |=> !irq);
endmodule

// File: tb/edge_event_capture_test.sv
module edge_event_capture_test;
  localparam int W = 16;
  localparam int NPAIR = 2;
  localparam int NPORT = 4;
  localparam int HX = 25;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic [NPORT*W-1:0] chan_in = '0;
  logic [NPORT-1:0]   bus_xact = '0;
  logic [NPORT-1:0]   ext_cap = '0;
  logic               host_wr = 1'b0;
  logic               host_rd = 1'b0;
  logic [2:0]         host_reg = '0;
  logic [0:0]         host_pair = '0;
  logic [W-1:0]       host_wdata = '0;
  logic [W-1:0]       host_rdata;
  logic [NPORT-1:0]   stat_edge, stat_dav;
  logic               irq;

  int n_chk = 0;
  int n_fail = 0;

  edge_event_capture #(.W(W), .NPAIR(NPAIR), .HOLD_EXT(HX)) uut (
    .clk(clk), .rst(rst), .chan_in(chan_in), .bus_xact(bus_xact), .ext_cap(ext_cap),
    .host_wr(host_wr), .host_rd(host_rd), .host_reg(host_reg), .host_pair(host_pair),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .stat_edge(stat_edge),
    .stat_dav(stat_dav), .irq(irq)
  );

  always #10 clk = ~clk;

  // rows: {new level on port 0, expected rising events, expected falling events}
  localparam logic [47:0] VEC [5] = '{
    {16'h00FF, 16'h00FF, 16'h0000},
    {16'h0F0F, 16'h0F00, 16'h00F0},
    {16'hFFFF, 16'hF0F0, 16'h0000},
    {16'h0000, 16'h0000, 16'hFFFF},
    {16'hA5A5, 16'hA5A5, 16'h0000}
  };

  task automatic chk(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] r, input logic p, input logic [W-1:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_reg = r; host_pair = p; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] r, input logic p, output logic [W-1:0] d);
    @(negedge clk);
    host_rd = 1'b1; host_reg = r; host_pair = p;
    @(negedge clk);
    host_rd = 1'b0;
    d = host_rdata;
  endtask

  task automatic set_in(input int p, input logic [W-1:0] v);
    @(negedge clk);
    chan_in[p*W +: W] = v;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
  endtask

  initial begin
    #4_000_000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [W-1:0] v;
    wait_cyc(3);
    @(negedge clk) rst = 1'b0;
    // R11 reset state
    chk("R11 rdata", host_rdata, '0);
    chk("R11 stat_edge", W'(stat_edge), '0);
    chk("R11 stat_dav", W'(stat_dav), '0);
    chk("R11 irq", W'(irq), '0);
    rd(3'd0, 1'b0, v); chk("R11 ctrl", v, '0);
    rd(3'd7, 1'b0, v); chk("R11 status", v, '0);

    // R4 table of edge patterns
    for (int i = 0; i < 5; i++) begin
      set_in(0, VEC[i][47:32]);
      wait_cyc(8);
      rd(3'd4, 1'b0, v); chk("R4 rising events", v, VEC[i][31:16]);
      rd(3'd5, 1'b0, v); chk("R4 falling events", v, VEC[i][15:0]);
      rd(3'd1, 1'b0, v); chk("R2 data level", v, VEC[i][47:32]);
      wr(3'd4, 1'b0, 16'hFFFF);
      wr(3'd5, 1'b0, 16'hFFFF);
    end

    // R2 latency
    set_in(0, 16'h3C3C);
    wait_cyc(3);
    rd(3'd1, 1'b0, v); chk("R2 read at edge 4", v, 16'hA5A5);
    rd(3'd1, 1'b0, v); chk("R2 read at edge 5", v, 16'h3C3C);

    // R1 hold window
    @(negedge clk) bus_xact[0] = 1'b1;
    set_in(0, 16'h1234);
    wait_cyc(10);
    rd(3'd1, 1'b0, v); chk("R1 during xact", v, 16'h3C3C);
    @(negedge clk) bus_xact[0] = 1'b0;
    wait_cyc(HX - 3);
    rd(3'd1, 1'b0, v); chk("R1 during extension", v, 16'h3C3C);
    wait_cyc(HX);
    rd(3'd1, 1'b0, v); chk("R1 after window", v, 16'h1234);
    wr(3'd4, 1'b0, 16'hFFFF);
    wr(3'd5, 1'b0, 16'hFFFF);

    // R6 set on the clear cycle wins
    set_in(0, 16'h1235);
    wait_cyc(3);
    wr(3'd4, 1'b0, 16'h0001);
    wait_cyc(4);
    rd(3'd4, 1'b0, v); chk("R6 set beats clear", v, 16'h0001);
    wr(3'd4, 1'b0, 16'h0001);
    rd(3'd4, 1'b0, v); chk("R6 write one clears", v, 16'h0000);

    // R5 masks
    wr(3'd2, 1'b0, 16'h00FF);
    wr(3'd3, 1'b0, 16'hFF00);
    set_in(0, 16'h0000);
    wait_cyc(8);
    rd(3'd5, 1'b0, v); chk("R5 falling mask", v, 16'h0035);
    set_in(0, 16'hFFFF);
    wait_cyc(8);
    rd(3'd4, 1'b0, v); chk("R5 rising mask", v, 16'hFF00);
    wr(3'd2, 1'b0, 16'h0000);
    wr(3'd3, 1'b0, 16'h0000);
    wr(3'd4, 1'b0, 16'hFFFF);
    wr(3'd5, 1'b0, 16'hFFFF);

    // R3 external capture, R7 data available
    wr(3'd0, 1'b0, 16'h0004);
    rd(3'd1, 1'b0, v);
    set_in(0, 16'h0F0F);
    wait_cyc(10);
    rd(3'd1, 1'b0, v); chk("R3 no strobe keeps data", v, 16'hFFFF);
    chk("R7 no capture no dav", W'(stat_dav), '0);
    @(negedge clk) ext_cap[0] = 1'b1;
    wait_cyc(3);
    @(negedge clk) ext_cap[0] = 1'b0;
    wait_cyc(8);
    chk("R7 capture sets dav", W'(stat_dav), 16'h0001);
    rd(3'd1, 1'b0, v); chk("R3 strobe loads data", v, 16'h0F0F);
    wait_cyc(3);
    chk("R7 data read clears dav", W'(stat_dav), '0);
    wr(3'd0, 1'b0, 16'h0000);
    wr(3'd4, 1'b0, 16'hFFFF);
    wr(3'd5, 1'b0, 16'hFFFF);

    // R10 bank select, R8 status layout
    set_in(2, 16'h0BEE);
    wait_cyc(8);
    wr(3'd7, 1'b0, 16'h0001);
    rd(3'd7, 1'b0, v); chk("R8 status word", v, 16'h0089);
    rd(3'd1, 1'b0, v); chk("R10 bank 1 pair 0", v, 16'h0BEE);
    wr(3'd7, 1'b0, 16'h0000);
    rd(3'd1, 1'b0, v); chk("R10 bank 0 pair 0", v, 16'h0F0F);

    // R8 / R9 interrupts
    wait_cyc(3);
    chk("R8 stat_edge port 2", W'(stat_edge), 16'h0004);
    chk("R9 edge not enabled", W'(irq), '0);
    wr(3'd7, 1'b0, 16'h0001);
    wr(3'd0, 1'b0, 16'h0001);
    wait_cyc(3);
    chk("R9 edge enabled", W'(irq), 16'h0001);
    wr(3'd4, 1'b0, 16'hFFFF);
    wait_cyc(3);
    chk("R9 edge cleared", W'(irq), '0);
    chk("R8 stat_edge cleared", W'(stat_edge), '0);
    wr(3'd0, 1'b1, 16'h0002);
    set_in(3, 16'h0001);
    wait_cyc(8);
    chk("R9 dav enabled", W'(irq), 16'h0001);
    rd(3'd1, 1'b1, v); chk("R10 bank 1 pair 1", v, 16'h0001);
    wait_cyc(3);
    chk("R9 dav cleared", W'(irq), '0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule